// File: doc/BRIEF.md
# Host Port Slave with Ready Handshake

This block lets an external host read and write a 32-bit internal address space over a 16-bit asynchronous strobe bus. The host lowers a chip select and toggles one of two data strobes. The block combines these into one active-low composite strobe. Each 32-bit word moves as two half-word transfers, and a half-word identifier line tells the two apart. A registered ready output holds the host until the block can finish the transfer. All host lines pass through two-flop synchronizers into the system clock.

When the strobe falls, two select bits pick one of four targets: a control register, an address register, data with address auto-increment, or data at a fixed address. On the internal side, a first-half read issues one request on a request/acknowledge read port. A small FIFO of address/data pairs holds word writes until the memory port accepts them. If the host releases the strobe before ready is given, the block drops that access.

Top module: `hostbus_slave`

## Requirements
- R1: The composite strobe is active (low) only while chip select is low and the two data strobes differ (strobe = NOT(ds1 XOR ds2) OR cs). With equal data strobes, or with chip select high, no access starts: ready stays high, no read request issues and the output enable stays low.
- R2: The select bits, read/write (1 = read) and half-word identifier (0 = low half, 1 = high half) are captured when the strobe falls. A later change on those pins does not affect the access in progress.
- R3: Ready (active low) is high after reset and while chip select is low before a strobe access is qualified. It goes low only when the access can complete.
- R4: A data read (select 10 or 11) of the low half raises `rd_req` with `rd_addr` equal to the address register. Ready stays high until `rd_ack`, when `rd_data` is loaded and its low half is driven on `h_dout`. In mode 10 the address register then increases by 4.
- R5: A data read of the high half issues no new request. It drives bits 31:16 of the word already loaded.
- R6: A data write stores the low half and pushes the word {high, low} with the address register when the high half is written. In mode 10 the address then increases by 4; in mode 11 it stays fixed. Words leave on `wr_valid`/`wr_ready` in push order and stay stable while they wait.
- R7: While the 4-entry write FIFO is full, a data write keeps ready high until an entry drains.
- R8: A write whose strobe rises while ready is still high is not committed.
- R9: `h_doe` is high only on a read access from strobe fall to strobe rise. It stays low on writes.
- R10: Select 00 reaches the control register and select 01 the address register. Both are read and written by half: half 0 is bits 15:0 and half 1 is bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_cs_n | input | 1 | Host chip select, active low |
| h_ds1 | input | 1 | Host data strobe 1 |
| h_ds2 | input | 1 | Host data strobe 2 |
| h_sel | input | 2 | Target select: 00 control, 01 address, 10 data auto-increment, 11 data fixed |
| h_rw | input | 1 | 1 = read, 0 = write |
| h_half | input | 1 | Half-word identifier: 0 low, 1 high |
| h_din | input | 16 | Host write data |
| h_dout | output | 16 | Host read data |
| h_doe | output | 1 | Read data output enable |
| h_rdy_n | output | 1 | Ready to host, active low |
| rd_req | output | 1 | Internal read request |
| rd_addr | output | 32 | Internal read address |
| rd_ack | input | 1 | Read acknowledge, with data valid |
| rd_data | input | 32 | Internal read data |
| wr_valid | output | 1 | Write FIFO head valid |
| wr_addr | output | 32 | Write FIFO head address |
| wr_data | output | 32 | Write FIFO head data |
| wr_ready | input | 1 | Memory port accepts the head entry |

## Verification
The checks take for granted a well-behaved host and memory side. The host holds select, read/write, half-word and data lines steady for several clocks around each strobe edge, so the synchronized copies agree. The memory side raises `rd_ack` only while `rd_req` is high. The bench host sets every select line four clocks before lowering a strobe and holds data four clocks past the release. Its memory model counts acknowledge delays only while the request is up and drops them when the request falls. The early-release case is the one deliberate break of the ready rule, made to show that the write is dropped.

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
  parameter int DEPTH = 4,
  parameter int INC   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_cs_n,
  input  logic        h_ds1,
  input  logic        h_ds2,
  input  logic [1:0]  h_sel,
  input  logic        h_rw,
  input  logic        h_half,
  input  logic [15:0] h_din,
  output logic [15:0] h_dout,
  output logic        h_doe,
  output logic        h_rdy_n,
  output logic        rd_req,
  output logic [31:0] rd_addr,
  input  logic        rd_ack,
  input  logic [31:0] rd_data,
  output logic        wr_valid,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  input  logic        wr_ready
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SW = 23;

  typedef enum logic [1:0] {IDLE, FETCH, WAITB, DONE} st_t;

  logic [SW-1:0] s1, s2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
    end else begin
      s1 <= {h_cs_n, h_ds1, h_ds2, h_sel, h_rw, h_half, h_din};
      s2 <= s1;
    end

  wire        cs_s   = s2[22];
  wire        ds1_s  = s2[21];
  wire        ds2_s  = s2[20];
  wire [1:0]  sel_s  = s2[19:18];
  wire        rw_s   = s2[17];
  wire        half_s = s2[16];
  wire [15:0] din_s  = s2[15:0];

  wire strb = ~(ds1_s ^ ds2_s) | cs_s;
  logic strb_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) strb_q <= 1'b1;
    else        strb_q <= strb;
  wire fall = strb_q & ~strb;
  wire rise = ~strb_q & strb;

  st_t        st;
  logic [1:0] sel_l;
  logic       rw_l, half_l;
  logic [31:0] ctrl_r, addr_r, data_r;
  logic [15:0] hold_r;

  logic [31:0]  af [DEPTH];
  logic [31:0]  df [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  wire full = (cnt == (PW+1)'(DEPTH));
  wire pop  = wr_valid & wr_ready;
  wire commit = (st == DONE) & rise & ~rw_l;
  wire push = commit & sel_l[1] & half_l;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= IDLE;
      sel_l  <= 2'b00;
      rw_l   <= 1'b0;
      half_l <= 1'b0;
      ctrl_r <= '0;
      addr_r <= '0;
      data_r <= '0;
      hold_r <= '0;
    end else begin
      case (st)
        IDLE:
          if (fall) begin
            sel_l  <= sel_s;
            rw_l   <= rw_s;
            half_l <= half_s;
            if (rw_s && sel_s[1] && !half_s)  st <= FETCH;
            else if (!rw_s && sel_s[1] && full) st <= WAITB;
            else                               st <= DONE;
          end
        FETCH:
          if (rise) st <= IDLE;
          else if (rd_ack) begin
            data_r <= rd_data;
            if (sel_l == 2'b10) addr_r <= addr_r + 32'(INC);
            st <= DONE;
          end
        WAITB:
          if (rise)       st <= IDLE;
          else if (!full) st <= DONE;
        DONE:
          if (rise) begin
            st <= IDLE;
            if (!rw_l) begin
              case (sel_l)
                2'b00: if (half_l) ctrl_r[31:16] <= din_s; else ctrl_r[15:0] <= din_s;
                2'b01: if (half_l) addr_r[31:16] <= din_s; else addr_r[15:0] <= din_s;
                default:
                  if (!half_l) hold_r <= din_s;
                  else if (sel_l == 2'b10) addr_r <= addr_r + 32'(INC);
              endcase
            end
          end
        default: st <= IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) begin
        af[wp] <= addr_r;
        df[wp] <= {din_s, hold_r};
        wp     <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
    end

  logic [31:0] rsrc;
  always_comb
    case (sel_l)
      2'b00:   rsrc = ctrl_r;
      2'b01:   rsrc = addr_r;
      default: rsrc = data_r;
    endcase

  assign h_dout   = half_l ? rsrc[31:16] : rsrc[15:0];
  assign h_doe    = rw_l & (st != IDLE);
  assign h_rdy_n  = (st != DONE);
  assign rd_req   = (st == FETCH);
  assign rd_addr  = addr_r;
  assign wr_valid = (cnt != '0);
  assign wr_addr  = af[rp];
  assign wr_data  = df[rp];
endmodule

module hostbus_slave_chk #(
  parameter int DEPTH = 4,
  parameter int PW = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        h_rdy_n,
  input logic        h_doe,
  input logic        rd_req,
  input logic        rd_ack,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data,
  input logic        push,
  input logic        full,
  input logic [PW:0] cnt
);
  // R4
  fetch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> h_rdy_n);
  // R4
  ack_ends_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n) (rd_req && rd_ack) |=> !rd_req);
  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= (PW+1)'(DEPTH));
  // R7
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> (!full || wr_ready));
  // R9
  doe_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> h_doe);
endmodule

bind hostbus_slave hostbus_slave_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_rdy_n(h_rdy_n), .h_doe(h_doe), .rd_req(rd_req),
  .rd_ack(rd_ack), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .push(push), .full(full), .cnt(cnt)
);

// File: tb/tb_hostbus_slave.sv
module tb_hostbus_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  // {sel[1:0], rw (1 = read), half, data or expected}
  localparam logic [19:0] VEC [NV] = '{
    {2'b01,1'b0,1'b0,16'h0010}, {2'b01,1'b0,1'b1,16'h0000},
    {2'b01,1'b1,1'b0,16'h0010}, {2'b01,1'b1,1'b1,16'h0000},
    {2'b00,1'b0,1'b0,16'hA5A5}, {2'b00,1'b1,1'b0,16'hA5A5},
    {2'b10,1'b0,1'b0,16'h1111}, {2'b10,1'b0,1'b1,16'h2222},
    {2'b10,1'b0,1'b0,16'h3333}, {2'b10,1'b0,1'b1,16'h4444},
    {2'b01,1'b1,1'b0,16'h0018}, {2'b01,1'b0,1'b0,16'h0010},
    {2'b11,1'b1,1'b0,16'h1111}, {2'b11,1'b1,1'b1,16'h2222},
    {2'b11,1'b1,1'b0,16'h1111}, {2'b10,1'b1,1'b0,16'h1111},
    {2'b10,1'b1,1'b1,16'h2222}, {2'b10,1'b1,1'b0,16'h3333},
    {2'b10,1'b1,1'b1,16'h4444}, {2'b01,1'b1,1'b0,16'h0018}
  };

  logic clk = 0, rst_n = 0;
  logic h_cs_n = 1, h_ds1 = 1, h_ds2 = 1, h_rw = 0, h_half = 0;
  logic [1:0] h_sel = 0;
  logic [15:0] h_din = 0, h_dout;
  logic h_doe, h_rdy_n, rd_req, rd_ack, wr_valid, wr_ready;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data;

  int checks = 0, errors = 0, fetches = 0, cyc = 0;
  logic mem_rdy = 1;
  logic [31:0] mem [16];
  logic [2:0] dly;
  logic req_q;

  hostbus_slave dut (.*);

  assign wr_ready = mem_rdy;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    req_q <= rd_req;
    if (rd_req && !req_q) fetches++;
    if (wr_valid && wr_ready) mem[wr_addr[5:2]] <= wr_data;
    if (rd_req && !rd_ack) begin
      dly <= dly + 1;
      if (dly == 3) begin rd_ack <= 1; rd_data <= mem[rd_addr[5:2]]; end
    end else begin
      rd_ack <= 0; dly <= 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  task automatic ncyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rdy(input int lim, output bit got);
    got = 0;
    for (int i = 0; i < lim && !got; i++) begin
      @(negedge clk);
      if (!h_rdy_n) got = 1;
    end
  endtask

  task automatic acc(input logic [1:0] sel, input logic rw, input logic half,
                     input logic [15:0] din, output logic [15:0] dq);
    bit got;
    @(negedge clk);
    h_cs_n = 0; h_sel = sel; h_rw = rw; h_half = half; h_din = din;
    ncyc(4);
    chk(h_rdy_n == 1, "R3", {31'b0, h_rdy_n}, 32'd1);
    h_ds1 = 0;
    wait_rdy(300, got);
    chk(got, "R3 ready given", {31'b0, got}, 32'd1);
    dq = h_dout;
    ncyc(1);
    h_ds1 = 1;
    ncyc(4);
    h_cs_n = 1;
    ncyc(2);
  endtask

  initial begin
    logic [15:0] dq;
    int f0;
    bit got;
    for (int i = 0; i < 16; i++) mem[i] = 0;
    rd_ack = 0; rd_data = 0; dly = 0; req_q = 0;
    ncyc(3);
    chk(h_rdy_n == 1 && h_doe == 0 && rd_req == 0 && wr_valid == 0, "R3 reset",
        {28'b0, h_rdy_n, h_doe, rd_req, wr_valid}, 32'h8);
    rst_n = 1;
    ncyc(3);

    for (int v = 0; v < NV; v++) begin
      f0 = fetches;
      acc(VEC[v][19:18], VEC[v][17], VEC[v][16], VEC[v][15:0], dq);
      if (VEC[v][17]) begin
        if (VEC[v][19]) begin
          if (VEC[v][16]) chk(fetches == f0, "R5 no refetch", fetches, f0);
          else            chk(fetches == f0 + 1, "R4 one fetch", fetches, f0 + 1);
          chk(dq == VEC[v][15:0], "R6 data readback", {16'b0, dq}, {16'b0, VEC[v][15:0]});
        end else
          chk(dq == VEC[v][15:0], "R10 register read", {16'b0, dq}, {16'b0, VEC[v][15:0]});
      end
    end

    // R1: equal strobes with chip select low, then differing strobes with chip select high
    f0 = fetches;
    @(negedge clk);
    h_cs_n = 0; h_sel = 2'b10; h_rw = 1; h_half = 0; h_ds1 = 0; h_ds2 = 0;
    ncyc(12);
    chk(h_rdy_n && !h_doe && fetches == f0, "R1 equal strobes", {30'b0, h_rdy_n, h_doe}, 32'h2);
    h_ds1 = 1; h_ds2 = 1; ncyc(3);
    h_cs_n = 1; h_ds1 = 0;
    ncyc(12);
    chk(h_rdy_n && !h_doe && fetches == f0, "R1 cs high", {30'b0, h_rdy_n, h_doe}, 32'h2);
    h_ds1 = 1; ncyc(4);

    // R7, R8: fill write FIFO, stall, release early
    acc(2'b01, 0, 0, 16'h0020, dq);
    acc(2'b01, 0, 1, 16'h0000, dq);
    mem_rdy = 0;
    for (int k = 0; k < 4; k++) begin
      acc(2'b11, 0, 0, 16'h0100 + 16'(k), dq);
      acc(2'b11, 0, 1, 16'h0200 + 16'(k), dq);
    end
    chk(wr_valid == 1, "R6 queued", {31'b0, wr_valid}, 32'd1);
    @(negedge clk);
    h_cs_n = 0; h_sel = 2'b11; h_rw = 0; h_half = 0; h_din = 16'hBEEF;
    ncyc(4);
    h_ds1 = 0;
    ncyc(20);
    chk(h_rdy_n == 1, "R7 full stall", {31'b0, h_rdy_n}, 32'd1);
    h_ds1 = 1;
    ncyc(6);
    h_cs_n = 1;
    mem_rdy = 1;
    ncyc(10);
    acc(2'b11, 0, 1, 16'h7777, dq);
    ncyc(10);
    acc(2'b11, 1, 0, 16'h0, dq);
    chk(dq == 16'h0103, "R8 aborted write", {16'b0, dq}, 32'h0103);
    acc(2'b11, 1, 1, 16'h0, dq);
    chk(dq == 16'h7777, "R6 high half", {16'b0, dq}, 32'h7777);

    // R9, R2: output enable window and select capture
    @(negedge clk);
    h_cs_n = 0; h_sel = 2'b01; h_rw = 1; h_half = 0;
    ncyc(4);
    chk(h_doe == 0, "R9 before strobe", {31'b0, h_doe}, 32'd0);
    h_ds1 = 0;
    wait_rdy(50, got);
    chk(got && h_doe == 1, "R9 during read", {30'b0, got, h_doe}, 32'h3);
    h_sel = 2'b00; h_half = 1;
    ncyc(6);
    chk(h_dout == 16'h0020, "R2 select held", {16'b0, h_dout}, 32'h0020);
    h_ds1 = 1;
    ncyc(6);
    chk(h_doe == 0, "R9 after release", {31'b0, h_doe}, 32'd0);
    h_cs_n = 1;
    ncyc(2);

    @(negedge clk);
    h_cs_n = 0; h_sel = 2'b00; h_rw = 0; h_half = 1; h_din = 16'h5A5A;
    ncyc(4);
    h_ds1 = 0;
    wait_rdy(50, got);
    chk(got && h_doe == 0, "R9 write no enable", {30'b0, got, h_doe}, 32'h2);
    ncyc(1);
    h_ds1 = 1; ncyc(4); h_cs_n = 1; ncyc(2);
    acc(2'b00, 1, 1, 16'h0, dq);
    chk(dq == 16'h5A5A, "R10 control high half", {16'b0, dq}, 32'h5A5A);
    acc(2'b00, 1, 0, 16'h0, dq);
    chk(dq == 16'hA5A5, "R10 control low half", {16'b0, dq}, 32'hA5A5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule